// File: doc/BRIEF.md
# Partitioned Crossbar Closed-Loop Programming Sequencer

This block programs a resistive crossbar that is split into several equal partitions, each with its own sense amplifier. A shared row and column address selects the same cell position in every partition at once. For that cell, each partition runs its own train of pulses: a read, then (if the sensed current has not yet reached target) a write followed by another read, until a read meets target. A partition that succeeds raises a one-cycle acknowledge and goes quiet. Once every partition has acknowledged, the address steps to the next position, column index first. After the last position a done flag rises.

Pulse widths are programmable cycle counts. A cap on write pulses per cell forces a partition's acknowledge and latches a sticky error bit for a cell that never converges. An inference mode hands every row over to the external input path. The comparator outputs reach the block as digital inputs. Drive levels, sensing and the weight mapping are outside the block.

Top module: `xbar_wv_ctrl`

## Requirements
- R1: After reset, the block is idle with `done` low, `err` zero, no pulses and address (0,0). A one-cycle `start` sets the address to (0,0) and clears `done` and `err` in the following cycle. In the cycle after that, every partition's `read_en` is high.
- R2: Within a partition, a read pulse whose comparator result is low is followed by a gap, a write pulse, another gap and a new read. `read_en` and `write_en` of one partition are never high together.
- R3: When the comparator is high in the last cycle of a read pulse, that partition raises `part_ack` for exactly one cycle. It then issues no further pulses for that cell.
- R4: The address advances, or `done` rises, in the cycle directly after the cycle in which the last outstanding partition acknowledge is high, and not before all partitions have acknowledged.
- R5: Positions are visited in this order: column 0 up to NUM_COL-1 within a row, then the next row, over ROWS_TOTAL/NUM_PART rows. Each position is visited exactly once per run.
- R6: The drive code of each row is 2 bits, at bits [2*(p*RPP+r)+1 : 2*(p*RPP+r)] for partition p, row r. Code 01 = read level, 10 = write level, 00 = mid-supply, 11 = external input. Only the addressed row of a partition that is pulsing carries 01 or 10, and all other rows carry 00. `row_onehot` and `col_onehot` have exactly the bit of the current index set.
- R7: `done` rises after the last position has been acknowledged. While `done` is high, no pulse enable is active.
- R8: While `infer_mode` is high, every row drive code is 11.
- R9: If a read fails after `max_writes` write pulses for the current cell, the partition acknowledges anyway and sets its `err` bit. `err` bits stay set until the next `start`. With `max_writes` = 0, the first failed read forces the acknowledge with no write.
- R10: A read pulse lasts `rd_width` cycles and a write pulse lasts `wr_width` cycles. A width or gap value of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Synchronous start of a programming run |
| infer_mode | input | 1 | Route all rows to the external input |
| rd_width | input | CNT_W | Read pulse width in cycles |
| wr_width | input | CNT_W | Write pulse width in cycles |
| gap_width | input | CNT_W | Idle cycles between pulses |
| max_writes | input | WCNT_W | Write pulse cap per cell |
| sense_ok | input | NUM_PART | Per-partition comparator: current reached target |
| row_idx | output | ROW_W | Addressed row within a partition |
| col_idx | output | COL_W | Addressed column |
| row_onehot | output | RPP | One-hot addressed row |
| col_onehot | output | NUM_COL | One-hot sensed column |
| row_mode | output | 2*NUM_PART*RPP | Per-row drive code |
| read_en | output | NUM_PART | Read pulse enable per partition |
| write_en | output | NUM_PART | Write pulse enable per partition |
| part_ack | output | NUM_PART | One-cycle acknowledge per partition |
| err | output | NUM_PART | Sticky write-cap error per partition |
| done | output | 1 | All positions programmed |

## Verification
The bench models each cell as needing a different number of writes per partition. This makes partitions finish at different times. A collector that advanced on the first acknowledge, or one that waited an extra cycle, would show up as an address change in the wrong cycle. Cells that need more writes than the cap check the forced acknowledge and the error latch. A sequencer that kept writing, or that cleared the error bit at the address step, would miscount writes or lose the bit. A second run uses zero widths and a zero cap, and a third run uses wide pulses. These runs expose width off-by-one errors and a `start` that fails to clear `err`. A finished partition's addressed row is watched for any stray drive, and the column-first order is checked against the expected visit list.

// File: rtl/xbar_wv_pkg.sv
// Package: drive codes and per-partition sequencer states shared by the
// crossbar programming sequencer. Assumes 2-bit row drive codes.
package xbar_wv_pkg;
    typedef enum logic [1:0] {
        DRV_MID   = 2'b00,
        DRV_READ  = 2'b01,
        DRV_WRITE = 2'b10,
        DRV_INFER = 2'b11
    } drv_mode_e;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_READ,
        PS_GAP_W,
        PS_WRITE,
        PS_GAP_R,
        PS_HOLD
    } pseq_state_e;
endpackage

// File: rtl/xbar_part_seq.sv
// Per-partition pulse sequencer: on go, runs read / gap / write / gap / read
// until the comparator is high at the last read cycle or the write cap is hit.
// Assumes go arrives only while idle or holding; clr has priority over go.
module xbar_part_seq
    import xbar_wv_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int WCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              go,
    input  logic              sense_ok,
    input  logic [CNT_W-1:0]  rd_width,
    input  logic [CNT_W-1:0]  wr_width,
    input  logic [CNT_W-1:0]  gap_width,
    input  logic [WCNT_W-1:0] max_writes,
    output logic              rd_pulse,
    output logic              wr_pulse,
    output logic              ack,
    output logic              err
);
    pseq_state_e       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WCNT_W-1:0] wcnt_q;

    // Width to counter load value; a zero width behaves as one cycle.
    function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] w);
        return (w == '0) ? '0 : w - 1'b1;
    endfunction

    // Pulse-train state machine with down-counter per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
            wcnt_q  <= '0;
            ack     <= 1'b0;
            err     <= 1'b0;
        end else begin
            ack <= 1'b0;
            if (clr) begin
                state_q <= PS_IDLE;
                wcnt_q  <= '0;
                err     <= 1'b0;
            end else if (go) begin
                state_q <= PS_READ;
                cnt_q   <= load_of(rd_width);
                wcnt_q  <= '0;
            end else begin
                case (state_q)
                    PS_READ: begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - 1'b1;
                        end else if (sense_ok) begin
                            ack     <= 1'b1;
                            state_q <= PS_HOLD;
                        end else if (wcnt_q >= max_writes) begin
                            ack     <= 1'b1;
                            err     <= 1'b1;
                            state_q <= PS_HOLD;
                        end else begin
                            state_q <= PS_GAP_W;
                            cnt_q   <= load_of(gap_width);
                        end
                    end
                    PS_GAP_W: begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - 1'b1;
                        end else begin
                            state_q <= PS_WRITE;
                            cnt_q   <= load_of(wr_width);
                        end
                    end
                    PS_WRITE: begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - 1'b1;
                        end else begin
                            state_q <= PS_GAP_R;
                            cnt_q   <= load_of(gap_width);
                            wcnt_q  <= wcnt_q + 1'b1;
                        end
                    end
                    PS_GAP_R: begin
                        if (cnt_q != '0) begin
                            cnt_q <= cnt_q - 1'b1;
                        end else begin
                            state_q <= PS_READ;
                            cnt_q   <= load_of(rd_width);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pulse enables follow the current phase.
    always_comb begin
        rd_pulse = (state_q == PS_READ);
        wr_pulse = (state_q == PS_WRITE);
    end
endmodule

// File: rtl/xbar_addr_gen.sv
// Shared cell address: column counter wraps into the row counter.
// Produces binary and one-hot selects and a last-position flag.
// Assumes step is never asserted at the last position.
module xbar_addr_gen #(
    parameter int RPP     = 2,
    parameter int NUM_COL = 4,
    parameter int ROW_W   = 1,
    parameter int COL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               step,
    output logic [ROW_W-1:0]   row_idx,
    output logic [COL_W-1:0]   col_idx,
    output logic [RPP-1:0]     row_onehot,
    output logic [NUM_COL-1:0] col_onehot,
    output logic               last
);
    logic col_wrap;

    // Column is at its final index.
    always_comb col_wrap = (col_idx == COL_W'(NUM_COL - 1));

    // Column-first address counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            row_idx <= '0;
            col_idx <= '0;
        end else if (step) begin
            if (col_wrap) begin
                col_idx <= '0;
                row_idx <= row_idx + 1'b1;
            end else begin
                col_idx <= col_idx + 1'b1;
            end
        end
    end

    // Final position flag.
    always_comb last = col_wrap && (row_idx == ROW_W'(RPP - 1));

    genvar gi;
    generate
        for (gi = 0; gi < RPP; gi++) begin : g_row_oh
            assign row_onehot[gi] = (row_idx == ROW_W'(gi));
        end
        for (gi = 0; gi < NUM_COL; gi++) begin : g_col_oh
            assign col_onehot[gi] = (col_idx == COL_W'(gi));
        end
    endgenerate
endmodule

// File: rtl/xbar_row_drive.sv
// Row drive selector: every row of every partition gets a 2-bit code.
// Inference overrides all; otherwise only the addressed row of a pulsing
// partition is driven, all others sit at mid-supply.
module xbar_row_drive
    import xbar_wv_pkg::*;
#(
    parameter int NUM_PART = 4,
    parameter int RPP      = 2,
    parameter int ROW_W    = 1
) (
    input  logic                    infer_mode,
    input  logic [ROW_W-1:0]        row_idx,
    input  logic [NUM_PART-1:0]     rd_pulse,
    input  logic [NUM_PART-1:0]     wr_pulse,
    output logic [2*NUM_PART*RPP-1:0] row_mode
);
    genvar gp, gr;
    generate
        for (gp = 0; gp < NUM_PART; gp++) begin : g_part
            for (gr = 0; gr < RPP; gr++) begin : g_row
                drv_mode_e sel;
                // Pick the drive code for this row.
                always_comb begin
                    if (infer_mode) begin
                        sel = DRV_INFER;
                    end else if (row_idx != ROW_W'(gr)) begin
                        sel = DRV_MID;
                    end else if (rd_pulse[gp]) begin
                        sel = DRV_READ;
                    end else if (wr_pulse[gp]) begin
                        sel = DRV_WRITE;
                    end else begin
                        sel = DRV_MID;
                    end
                end
                assign row_mode[2*(gp*RPP+gr) +: 2] = sel;
            end
        end
    endgenerate
endmodule

// File: rtl/xbar_wv_ctrl.sv
// Top: partitioned crossbar closed-loop programming sequencer.
// Collects per-partition acknowledges in a sticky vector and steps the shared
// address on the edge after the last one arrives. Assumes ROWS_TOTAL is a
// multiple of NUM_PART.
module xbar_wv_ctrl #(
    parameter int NUM_PART   = 4,
    parameter int ROWS_TOTAL = 8,
    parameter int NUM_COL    = 4,
    parameter int CNT_W      = 6,
    parameter int WCNT_W     = 4,
    localparam int RPP       = ROWS_TOTAL / NUM_PART,
    localparam int ROW_W     = (RPP > 1) ? $clog2(RPP) : 1,
    localparam int COL_W     = (NUM_COL > 1) ? $clog2(NUM_COL) : 1,
    localparam int MODE_W    = 2 * NUM_PART * RPP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                infer_mode,
    input  logic [CNT_W-1:0]    rd_width,
    input  logic [CNT_W-1:0]    wr_width,
    input  logic [CNT_W-1:0]    gap_width,
    input  logic [WCNT_W-1:0]   max_writes,
    input  logic [NUM_PART-1:0] sense_ok,
    output logic [ROW_W-1:0]    row_idx,
    output logic [COL_W-1:0]    col_idx,
    output logic [RPP-1:0]      row_onehot,
    output logic [NUM_COL-1:0]  col_onehot,
    output logic [MODE_W-1:0]   row_mode,
    output logic [NUM_PART-1:0] read_en,
    output logic [NUM_PART-1:0] write_en,
    output logic [NUM_PART-1:0] part_ack,
    output logic [NUM_PART-1:0] err,
    output logic                done
);
    logic                running_q;
    logic                go_q;
    logic [NUM_PART-1:0] sticky_q;
    logic                all_in;
    logic                last;
    logic                step;

    // Every partition has acknowledged this cell (latched or arriving now).
    always_comb all_in = &(sticky_q | part_ack);

    // Address step request when a non-final cell completes.
    always_comb step = running_q && all_in && !start && !last;

    // Run control, acknowledge collector and cell kick-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            done      <= 1'b0;
            go_q      <= 1'b0;
            sticky_q  <= '0;
        end else begin
            go_q <= 1'b0;
            if (start) begin
                running_q <= 1'b1;
                done      <= 1'b0;
                go_q      <= 1'b1;
                sticky_q  <= '0;
            end else if (running_q && all_in) begin
                sticky_q <= '0;
                if (last) begin
                    running_q <= 1'b0;
                    done      <= 1'b1;
                end else begin
                    go_q <= 1'b1;
                end
            end else if (running_q) begin
                sticky_q <= sticky_q | part_ack;
            end
        end
    end

    xbar_addr_gen #(
        .RPP(RPP), .NUM_COL(NUM_COL), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(start), .step(step),
        .row_idx(row_idx), .col_idx(col_idx),
        .row_onehot(row_onehot), .col_onehot(col_onehot), .last(last)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PART; gp++) begin : g_seq
            xbar_part_seq #(.CNT_W(CNT_W), .WCNT_W(WCNT_W)) u_seq (
                .clk(clk), .rst_n(rst_n), .clr(start), .go(go_q),
                .sense_ok(sense_ok[gp]),
                .rd_width(rd_width), .wr_width(wr_width),
                .gap_width(gap_width), .max_writes(max_writes),
                .rd_pulse(read_en[gp]), .wr_pulse(write_en[gp]),
                .ack(part_ack[gp]), .err(err[gp])
            );
        end
    endgenerate

    xbar_row_drive #(.NUM_PART(NUM_PART), .RPP(RPP), .ROW_W(ROW_W)) u_drive (
        .infer_mode(infer_mode), .row_idx(row_idx),
        .rd_pulse(read_en), .wr_pulse(write_en), .row_mode(row_mode)
    );
endmodule

// File: rtl/xbar_wv_chk.sv
// Checker for the programming sequencer, bound to the top module.
// Watches port-level timing rules of the pulse trains, acknowledges and address.
module xbar_wv_chk #(
    parameter int NUM_PART = 4,
    parameter int ROW_W    = 1,
    parameter int COL_W    = 2,
    parameter int NUM_COL  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [ROW_W-1:0]    row_idx,
    input logic [COL_W-1:0]    col_idx,
    input logic [NUM_COL-1:0]  col_onehot,
    input logic [NUM_PART-1:0] read_en,
    input logic [NUM_PART-1:0] write_en,
    input logic [NUM_PART-1:0] part_ack,
    input logic [NUM_PART-1:0] err,
    input logic                done
);
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (read_en & write_en) == '0); // R2
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(col_onehot) == 1) && col_onehot[col_idx]); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((read_en | write_en) == '0)); // R7
    AST_COL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && (col_idx != $past(col_idx)) && (col_idx != '0))
        |-> (row_idx == $past(row_idx))); // R5

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PART; gp++) begin : g_p
            AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
                part_ack[gp] |=> !part_ack[gp]); // R3
            AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                part_ack[gp] |-> (!read_en[gp] && !write_en[gp])); // R3
            AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                (err[gp] && !start) |=> err[gp]); // R9
        end
    endgenerate
endmodule

bind xbar_wv_ctrl xbar_wv_chk #(
    .NUM_PART(NUM_PART), .ROW_W(ROW_W), .COL_W(COL_W), .NUM_COL(NUM_COL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .row_idx(row_idx), .col_idx(col_idx), .col_onehot(col_onehot),
    .read_en(read_en), .write_en(write_en), .part_ack(part_ack),
    .err(err), .done(done)
);

// File: tb/xbar_wv_ctrl_tb.sv
// Scoreboard bench: the driver pushes one expected item per cell; the
// monitor emulates per-partition devices and compares at each address step.
module xbar_wv_ctrl_tb;
    localparam int NP = 4, RT = 8, NC = 4, CW = 6, WW = 4;
    localparam int RPP = RT / NP;
    localparam int MW = 2 * NP * RPP;

    typedef struct packed {
        logic [3:0]            row;
        logic [3:0]            col;
        logic [NP-1:0][3:0]    writes;
        logic [NP-1:0]         errv;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, infer_mode = 1'b0;
    logic [CW-1:0] rd_width = '0, wr_width = '0, gap_width = '0;
    logic [WW-1:0] max_writes = '0;
    logic [NP-1:0] sense_ok = '0;
    logic [0:0] row_idx;
    logic [1:0] col_idx;
    logic [RPP-1:0] row_onehot;
    logic [NC-1:0] col_onehot;
    logic [MW-1:0] row_mode;
    logic [NP-1:0] read_en, write_en, part_ack, err;
    logic done;

    always #2 clk = ~clk;

    xbar_wv_ctrl #(.NUM_PART(NP), .ROWS_TOTAL(RT), .NUM_COL(NC),
                   .CNT_W(CW), .WCNT_W(WW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .infer_mode(infer_mode),
        .rd_width(rd_width), .wr_width(wr_width), .gap_width(gap_width),
        .max_writes(max_writes), .sense_ok(sense_ok),
        .row_idx(row_idx), .col_idx(col_idx), .row_onehot(row_onehot),
        .col_onehot(col_onehot), .row_mode(row_mode), .read_en(read_en),
        .write_en(write_en), .part_ack(part_ack), .err(err), .done(done)
    );

    int n_chk = 0, n_fail = 0;
    item_t exp_q[$];
    int need[NP], wcount[NP], acks[NP], rd_run[NP], wr_run[NP];
    int drive_bad = 0, width_bad = 0, adv_bad = 0;
    logic [NP-1:0] prev_rd = '0, prev_wr = '0;
    int prev_row = 0, prev_col = 0;
    logic prev_done = 1'b0, pend = 1'b0, was_all = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int need_of(input int r, input int c, input int p);
        return (r * 5 + c * 3 + p) % 5;
    endfunction

    function automatic int eff(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    // Monitor: device model, pulse accounting and scoreboard compare.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start) begin
                for (int p = 0; p < NP; p++) begin
                    wcount[p] = 0; acks[p] = 0; rd_run[p] = 0; wr_run[p] = 0;
                    need[p] = need_of(0, 0, p);
                end
                pend = 1'b0; was_all = 1'b0;
            end else begin
                bit adv, all_now;
                adv = (int'(row_idx) != prev_row) || (int'(col_idx) != prev_col)
                      || (done && !prev_done);
                if (pend) begin
                    if (!adv) adv_bad++;  // R4: step one cycle after last ack
                    pend = 1'b0;
                end
                if (adv) begin
                    item_t it;
                    if (exp_q.size() == 0) begin
                        check(0, "R5 unexpected cell", prev_row * NC + prev_col, -1);
                    end else begin
                        it = exp_q.pop_front();
                        check(int'(it.row) == prev_row && int'(it.col) == prev_col,
                              "R5 visit order", prev_row * NC + prev_col,
                              int'(it.row) * NC + int'(it.col));
                        for (int p = 0; p < NP; p++) begin
                            check(wcount[p] == int'(it.writes[p]), "R2 write count",
                                  wcount[p], int'(it.writes[p]));
                            check(acks[p] == 1, "R3 ack count", acks[p], 1);
                        end
                        check(err == it.errv, "R9 error bits", int'(err), int'(it.errv));
                    end
                    for (int p = 0; p < NP; p++) begin
                        wcount[p] = 0; acks[p] = 0;
                        need[p] = need_of(int'(row_idx), int'(col_idx), p);
                    end
                end
                for (int p = 0; p < NP; p++) begin
                    if (write_en[p] && !prev_wr[p]) wcount[p]++;
                    if (part_ack[p]) acks[p]++;
                    if (read_en[p]) rd_run[p]++;
                    if (write_en[p]) wr_run[p]++;
                    if (!read_en[p] && prev_rd[p]) begin
                        if (rd_run[p] != eff(int'(rd_width))) width_bad++;  // R10
                        rd_run[p] = 0;
                    end
                    if (!write_en[p] && prev_wr[p]) begin
                        if (wr_run[p] != eff(int'(wr_width))) width_bad++;  // R10
                        wr_run[p] = 0;
                    end
                    if (!infer_mode) begin
                        for (int r = 0; r < RPP; r++) begin
                            logic [1:0] m, e;
                            m = row_mode[2*(p*RPP+r) +: 2];
                            if (r != int'(row_idx)) e = 2'b00;
                            else if (read_en[p]) e = 2'b01;
                            else if (write_en[p]) e = 2'b10;
                            else e = 2'b00;
                            if (m != e) drive_bad++;  // R6
                        end
                        if (acks[p] > 0 && (read_en[p] || write_en[p])) drive_bad++;  // R3
                    end
                end
                if (!row_onehot[row_idx] || $countones(row_onehot) != 1) drive_bad++;  // R6
                all_now = 1'b1;
                for (int p = 0; p < NP; p++) if (acks[p] == 0) all_now = 1'b0;
                if (all_now && !was_all) pend = 1'b1;
                was_all = all_now;
            end
            for (int p = 0; p < NP; p++) sense_ok[p] <= (wcount[p] >= need[p]);
            prev_rd = read_en; prev_wr = write_en;
            prev_row = int'(row_idx); prev_col = int'(col_idx);
            prev_done = done;
        end
    end

    // Driver: program one run and push the expected per-cell outcomes.
    task automatic run(input int rd, input int wr, input int gap, input int mw);
        logic [NP-1:0] cum;
        cum = '0;
        rd_width <= CW'(rd); wr_width <= CW'(wr); gap_width <= CW'(gap);
        max_writes <= WW'(mw);
        for (int r = 0; r < RPP; r++) begin
            for (int c = 0; c < NC; c++) begin
                item_t it;
                it.row = 4'(r); it.col = 4'(c);
                for (int p = 0; p < NP; p++) begin
                    int n;
                    n = need_of(r, c, p);
                    it.writes[p] = 4'((n > mw) ? mw : n);
                    if (n > mw) cum[p] = 1'b1;
                end
                it.errv = cum;
                exp_q.push_back(it);
            end
        end
        @(negedge clk); start <= 1'b1;
        @(negedge clk); start <= 1'b0;
        check(done == 1'b0, "R1 done cleared", int'(done), 0);
        check(err == '0, "R1 err cleared", int'(err), 0);
        check(row_idx == '0 && col_idx == '0, "R1 address reset",
              int'({row_idx, col_idx}), 0);
        @(negedge clk);
        check(read_en == '1, "R1 first pulse is read", int'(read_en), (1 << NP) - 1);
        while (!done) @(negedge clk);
        @(negedge clk);
        check(read_en == '0 && write_en == '0, "R7 quiet when done",
              int'({read_en, write_en}), 0);
        check(exp_q.size() == 0, "R7 all cells visited", exp_q.size(), 0);
        check(cum == err, "R9 final error bits", int'(err), int'(cum));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        check(done == 1'b0 && err == '0, "R1 reset flags", int'({done, err}), 0);
        check(read_en == '0 && write_en == '0, "R1 reset pulses",
              int'({read_en, write_en}), 0);
        check(row_idx == '0 && col_idx == '0, "R1 reset address",
              int'({row_idx, col_idx}), 0);
        check(row_mode == '0, "R6 reset rows mid-supply", int'(row_mode), 0);

        run(2, 3, 1, 3);

        infer_mode <= 1'b1;
        @(negedge clk);
        check(row_mode == '1, "R8 inference routes all rows", int'(row_mode), (1 << MW) - 1);
        infer_mode <= 1'b0;
        @(negedge clk);
        check(row_mode == '0, "R8 inference released", int'(row_mode), 0);

        run(0, 1, 0, 0);
        run(3, 2, 2, 4);

        check(drive_bad == 0, "R6 row drive violations", drive_bad, 0);
        check(width_bad == 0, "R10 pulse width violations", width_bad, 0);
        check(adv_bad == 0, "R4 advance latency violations", adv_bad, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule